// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block runs one scan over a chosen subset of up to four analog inputs, using an abstract converter. Each conversion is requested with a one-cycle start strobe and a channel index. The converter answers with a one-cycle done strobe and an 8-bit code. The sequencer sends requests for the selected channels one at a time, in ascending index order, and skips the channels that are not selected. It stores every returned code in a result register that belongs to that channel.

When the last selected channel has been stored, a sticky completion flag is set. A window comparator looks at the upper four bits of every stored code. If that nibble is below the low limit or above the high limit, it sets a sticky out-of-window flag. Each flag has its own enable, which gates it onto an interrupt line. A scan with no channel selected finishes at once and issues no conversion.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `busy_o`, `conv_start_o`, both flags and both interrupt lines are 0, and every result register reads 0.
- R2: A scan converts each selected channel exactly once, in ascending index order, and skips unselected channels. `conv_chan_o` carries the binary channel index while `conv_start_o` is high.
- R3: The code returned for channel k is stored in bits [8k+7:8k] of `result_o` on the clock edge that samples `conv_done_i`. The registers of unselected channels keep their values.
- R4: `done_flag_o` goes to 1 on the same edge that stores the last selected result, and `busy_o` falls on that edge.
- R5: A start with an all-zero selection issues no conversion request. It sets `done_flag_o` on the edge that samples the start, and `busy_o` stays 0.
- R6: `start_i` and `sel_i` are ignored while a scan is running: the running scan's channel set and its results are unchanged.
- R7: A stored code whose bits [7:4] are less than `lo_lim_i` or greater than `hi_lim_i` sets `bnd_flag_o`. A nibble equal to either limit is inside the window. Every stored code of the scan is checked.
- R8: Both flags stay set until their clear input is high at a clock edge. When a set event and a clear fall on the same edge, the flag ends up set.
- R9: `irq_done_o` is `done_flag_o` gated by `done_ie_i`, and `irq_bnd_o` is `bnd_flag_o` gated by `bnd_ie_i`.
- R10: `conv_start_o` lasts one cycle, and only one conversion is outstanding at a time. A `conv_done_i` that arrives while no conversion is outstanding changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Scan start request |
| sel_i | input | 4 | Channel selection, bit k selects channel k |
| lo_lim_i | input | 4 | Low window limit for the result nibble |
| hi_lim_i | input | 4 | High window limit for the result nibble |
| done_ie_i | input | 1 | Completion interrupt enable |
| bnd_ie_i | input | 1 | Out-of-window interrupt enable |
| done_clr_i | input | 1 | Clears the completion flag |
| bnd_clr_i | input | 1 | Clears the out-of-window flag |
| conv_start_o | output | 1 | Conversion request strobe |
| conv_chan_o | output | 2 | Channel index of the request |
| conv_done_i | input | 1 | Conversion finished strobe |
| conv_data_i | input | 8 | Converted code |
| busy_o | output | 1 | Scan in progress |
| result_o | output | 32 | Per-channel result registers, channel k in [8k+7:8k] |
| done_flag_o | output | 1 | Sticky completion flag |
| bnd_flag_o | output | 1 | Sticky out-of-window flag |
| irq_done_o | output | 1 | Completion interrupt |
| irq_bnd_o | output | 1 | Out-of-window interrupt |

## Verification
The clear inputs can land on the same edge as the events that set the flags. One case is the final done strobe, which both stores an out-of-window code and ends the scan. The bench provokes this by raising both clear inputs in the very cycle its converter model returns the last code of a one-channel scan. The design is correct if both flags read 1 afterwards, and both read 0 after one further clear on its own.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int SCAN_NCH  = 4;
  localparam int SCAN_DW   = 8;
  localparam int SCAN_CMPW = 4;

  typedef enum logic [1:0] {
    SC_IDLE  = 2'd0,
    SC_ISSUE = 2'd1,
    SC_WAIT  = 2'd2
  } scan_state_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NCH = SCAN_NCH,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [NCH-1:0] sel_i,
  input  logic           conv_done_i,
  output logic           conv_start_o,
  output logic [CW-1:0]  conv_chan_o,
  output logic           busy_o,
  output logic           store_o,
  output logic [CW-1:0]  store_chan_o,
  output logic           scan_fin_o
);
  scan_state_t    state_q;
  logic [NCH-1:0] pend_q;
  logic [CW-1:0]  head;
  logic [NCH-1:0] rest;

  // index of the lowest pending channel
  function automatic logic [CW-1:0] first_set(input logic [NCH-1:0] m);
    logic [CW-1:0] idx;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (m[i]) idx = CW'(i);
    end
    return idx;
  endfunction

  function automatic logic [NCH-1:0] drop_bit(input logic [NCH-1:0] m,
                                               input logic [CW-1:0] idx);
    logic [NCH-1:0] r;
    r = m;
    r[idx] = 1'b0;
    return r;
  endfunction

  assign head = first_set(pend_q);
  assign rest = drop_bit(pend_q, head);

  logic launch_empty;
  logic last_back;
  assign launch_empty = (state_q == SC_IDLE) && start_i && (sel_i == '0);
  assign last_back    = (state_q == SC_WAIT) && conv_done_i && (rest == '0);

  assign conv_start_o = (state_q == SC_ISSUE);
  assign conv_chan_o  = head;
  assign busy_o       = (state_q != SC_IDLE);
  assign store_o      = (state_q == SC_WAIT) && conv_done_i;
  assign store_chan_o = head;
  assign scan_fin_o   = launch_empty || last_back;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SC_IDLE;
      pend_q  <= '0;
    end else begin
      unique case (state_q)
        SC_IDLE: begin
          if (start_i) begin
            pend_q <= sel_i;
            if (sel_i != '0) state_q <= SC_ISSUE;
          end
        end
        SC_ISSUE: state_q <= SC_WAIT;
        SC_WAIT: begin
          if (conv_done_i) begin
            pend_q  <= rest;
            state_q <= (rest == '0) ? SC_IDLE : SC_ISSUE;
          end
        end
        default: state_q <= SC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/result_bank.sv
module result_bank
  import adc_scan_pkg::*;
#(
  parameter int NCH = SCAN_NCH,
  parameter int DW  = SCAN_DW,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            store_i,
  input  logic [CW-1:0]   chan_i,
  input  logic [DW-1:0]   data_i,
  output logic [NCH-1:0]  we_o,
  output logic [NCH*DW-1:0] res_o
);
  for (genvar k = 0; k < NCH; k++) begin : g_slot
    logic [DW-1:0] slot_q;
    assign we_o[k] = store_i && (chan_i == CW'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (we_o[k]) slot_q <= data_i;
    end
    assign res_o[k*DW +: DW] = slot_q;
  end
endmodule

// File: rtl/bound_cmp.sv
module bound_cmp
  import adc_scan_pkg::*;
#(
  parameter int DW   = SCAN_DW,
  parameter int CMPW = SCAN_CMPW
) (
  input  logic            valid_i,
  input  logic [DW-1:0]   data_i,
  input  logic [CMPW-1:0] lo_i,
  input  logic [CMPW-1:0] hi_i,
  output logic            hit_o
);
  // upper CMPW bits compared against an inclusive window
  function automatic logic outside(input logic [DW-1:0] d,
                                   input logic [CMPW-1:0] lo,
                                   input logic [CMPW-1:0] hi);
    logic [CMPW-1:0] top;
    top = d[DW-1 -: CMPW];
    return (top < lo) || (top > hi);
  endfunction

  assign hit_o = valid_i && outside(data_i, lo_i, hi_i);
endmodule

// File: rtl/flag_reg.sv
module flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NCH  = SCAN_NCH,
  parameter int DW   = SCAN_DW,
  parameter int CMPW = SCAN_CMPW,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [NCH-1:0]    sel_i,
  input  logic [CMPW-1:0]   lo_lim_i,
  input  logic [CMPW-1:0]   hi_lim_i,
  input  logic              done_ie_i,
  input  logic              bnd_ie_i,
  input  logic              done_clr_i,
  input  logic              bnd_clr_i,
  output logic              conv_start_o,
  output logic [CW-1:0]     conv_chan_o,
  input  logic              conv_done_i,
  input  logic [DW-1:0]     conv_data_i,
  output logic              busy_o,
  output logic [NCH*DW-1:0] result_o,
  output logic              done_flag_o,
  output logic              bnd_flag_o,
  output logic              irq_done_o,
  output logic              irq_bnd_o
);
  // named internal events, observed by the checker
  logic           ev_store;
  logic [CW-1:0]  ev_store_chan;
  logic           ev_scan_fin;
  logic           ev_bnd_hit;
  logic [NCH-1:0] ev_slot_we;

  scan_ctrl #(.NCH(NCH)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .sel_i        (sel_i),
    .conv_done_i  (conv_done_i),
    .conv_start_o (conv_start_o),
    .conv_chan_o  (conv_chan_o),
    .busy_o       (busy_o),
    .store_o      (ev_store),
    .store_chan_o (ev_store_chan),
    .scan_fin_o   (ev_scan_fin)
  );

  result_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .store_i(ev_store),
    .chan_i (ev_store_chan),
    .data_i (conv_data_i),
    .we_o   (ev_slot_we),
    .res_o  (result_o)
  );

  bound_cmp #(.DW(DW), .CMPW(CMPW)) u_cmp (
    .valid_i(ev_store),
    .data_i (conv_data_i),
    .lo_i   (lo_lim_i),
    .hi_i   (hi_lim_i),
    .hit_o  (ev_bnd_hit)
  );

  flag_reg u_done_flag (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(ev_scan_fin),
    .clr_i(done_clr_i),
    .q_o  (done_flag_o)
  );

  flag_reg u_bnd_flag (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(ev_bnd_hit),
    .clr_i(bnd_clr_i),
    .q_o  (bnd_flag_o)
  );

  assign irq_done_o = done_flag_o && done_ie_i;
  assign irq_bnd_o  = bnd_flag_o && bnd_ie_i;
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic           busy_o,
  input logic           conv_start_o,
  input logic           conv_done_i,
  input logic           done_flag_o,
  input logic           done_clr_i,
  input logic           bnd_flag_o,
  input logic           bnd_clr_i,
  input logic           irq_done_o,
  input logic           done_ie_i,
  input logic           ev_scan_fin,
  input logic           ev_bnd_hit,
  input logic           ev_store,
  input logic [NCH-1:0] ev_slot_we
);
  p_start_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);

  p_idle_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !conv_start_o);

  p_no_store_on_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> !ev_store);

  p_one_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_slot_we));

  p_fin_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_scan_fin |=> done_flag_o);

  p_fin_drops_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_scan_fin |=> !busy_o);

  p_hit_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bnd_hit |=> bnd_flag_o);

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_flag_o && !done_clr_i |=> done_flag_o);

  p_bnd_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_flag_o && bnd_clr_i && !ev_bnd_hit |=> !bnd_flag_o);

  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !ev_scan_fin |=> busy_o);

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done_o |-> done_ie_i);
endmodule

bind adc_scan_seq adc_scan_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .conv_start_o(conv_start_o),
  .conv_done_i (conv_done_i),
  .done_flag_o (done_flag_o),
  .done_clr_i  (done_clr_i),
  .bnd_flag_o  (bnd_flag_o),
  .bnd_clr_i   (bnd_clr_i),
  .irq_done_o  (irq_done_o),
  .done_ie_i   (done_ie_i),
  .ev_scan_fin (ev_scan_fin),
  .ev_bnd_hit  (ev_bnd_hit),
  .ev_store    (ev_store),
  .ev_slot_we  (ev_slot_we)
);

// File: tb/adc_scan_seq_bench.sv
`timescale 1ns/1ps
module adc_scan_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  sel_i = '0;
  logic [3:0]  lo_lim_i = 4'd4;
  logic [3:0]  hi_lim_i = 4'd11;
  logic        done_ie_i = 1'b0;
  logic        bnd_ie_i = 1'b0;
  logic        done_clr_i, bnd_clr_i;
  logic        conv_start_o;
  logic [1:0]  conv_chan_o;
  logic        conv_done_i;
  logic [7:0]  conv_data_i;
  logic        busy_o;
  logic [31:0] result_o;
  logic        done_flag_o, bnd_flag_o, irq_done_o, irq_bnd_o;

  // bench-side stimulus sources
  logic       clr_req = 1'b0;
  logic       collide_pulse = 1'b0;
  logic       collide_mode = 1'b0;
  logic       model_done = 1'b0;
  logic [7:0] model_data = '0;
  logic       stray_done = 1'b0;
  logic [7:0] stray_data = '0;

  assign done_clr_i  = clr_req | collide_pulse;
  assign bnd_clr_i   = clr_req | collide_pulse;
  assign conv_done_i = model_done | stray_done;
  assign conv_data_i = model_done ? model_data : stray_data;

  always #2.5 clk = ~clk;

  adc_scan_seq u_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_i),
    .lo_lim_i(lo_lim_i), .hi_lim_i(hi_lim_i),
    .done_ie_i(done_ie_i), .bnd_ie_i(bnd_ie_i),
    .done_clr_i(done_clr_i), .bnd_clr_i(bnd_clr_i),
    .conv_start_o(conv_start_o), .conv_chan_o(conv_chan_o),
    .conv_done_i(conv_done_i), .conv_data_i(conv_data_i),
    .busy_o(busy_o), .result_o(result_o),
    .done_flag_o(done_flag_o), .bnd_flag_o(bnd_flag_o),
    .irq_done_o(irq_done_o), .irq_bnd_o(irq_bnd_o)
  );

  int total = 0;
  int bad = 0;
  logic [7:0] data_tab [4];
  logic [7:0] res_exp [4];
  int log_ch [8];
  int log_n = 0;
  int cnt = 0;
  int cur_ch = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model: latency depends on channel
  always @(negedge clk) begin
    model_done = 1'b0;
    collide_pulse = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        model_done = 1'b1;
        model_data = data_tab[cur_ch];
        if (collide_mode) collide_pulse = 1'b1;
      end
    end else if (conv_start_o) begin
      cur_ch = int'(conv_chan_o);
      if (log_n < 8) log_ch[log_n] = cur_ch;
      log_n++;
      cnt = 1 + (cur_ch % 3);
    end
  end

  function automatic bit nib_out(input logic [7:0] d, input logic [3:0] lo,
                                 input logic [3:0] hi);
    int n;
    n = int'(d) / 16;
    return (n < int'(lo)) || (n > int'(hi));
  endfunction

  task automatic clear_flags();
    @(negedge clk) clr_req = 1'b1;
    @(negedge clk) clr_req = 1'b0;
    check(done_flag_o == 1'b0, "R8 done flag cleared", done_flag_o, 0);
    check(bnd_flag_o == 1'b0, "R8 bnd flag cleared", bnd_flag_o, 0);
  endtask

  task automatic check_results(input string tag);
    for (int k = 0; k < 4; k++)
      check(result_o[k*8 +: 8] == res_exp[k], tag, result_o[k*8 +: 8], res_exp[k]);
  endtask

  task automatic run_scan(input logic [3:0] m, input bit poke_busy);
    int guard;
    int exp_n;
    bit exp_b;
    log_n = 0;
    @(negedge clk);
    sel_i = m;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke_busy && busy_o) begin
      sel_i = ~m;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    guard = 0;
    while (busy_o && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    exp_n = 0;
    exp_b = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (m[k]) begin
        res_exp[k] = data_tab[k];
        if (exp_n < 8)
          check(log_ch[exp_n] == k, "R2 ascending channel order", log_ch[exp_n], k);
        exp_n++;
        if (nib_out(data_tab[k], lo_lim_i, hi_lim_i)) exp_b = 1'b1;
      end
    end
    check(log_n == exp_n, poke_busy ? "R6 request count with start while busy"
                                    : "R2 one request per selected channel", log_n, exp_n);
    check(busy_o == 1'b0, "R4 busy low after scan", busy_o, 0);
    check(done_flag_o == 1'b1, (m == 0) ? "R5 empty scan completes" : "R4 done flag set",
          done_flag_o, 1);
    check_results(poke_busy ? "R6 results after ignored start" : "R3 per-channel results");
    check(bnd_flag_o == exp_b, "R7 boundary flag", bnd_flag_o, exp_b);
    check(irq_done_o == done_ie_i, "R9 done interrupt gating", irq_done_o, done_ie_i);
    check(irq_bnd_o == (exp_b & bnd_ie_i), "R9 boundary interrupt gating", irq_bnd_o,
          exp_b & bnd_ie_i);
  endtask

  initial begin
    #(5.0 * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) begin
      data_tab[k] = '0;
      res_exp[k] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy_o == 1'b0, "R1 busy at reset", busy_o, 0);
    check(conv_start_o == 1'b0, "R1 no request at reset", conv_start_o, 0);
    check(done_flag_o == 1'b0 && bnd_flag_o == 1'b0, "R1 flags at reset",
          {done_flag_o, bnd_flag_o}, 0);
    check(irq_done_o == 1'b0 && irq_bnd_o == 1'b0, "R1 irq at reset",
          {irq_done_o, irq_bnd_o}, 0);
    check(result_o == '0, "R1 results at reset", result_o, 0);

    // sweep every selection twice with different data
    for (int pass = 0; pass < 2; pass++) begin
      for (int m = 0; m < 16; m++) begin
        for (int k = 0; k < 4; k++)
          data_tab[k] = 8'((m * 37 + k * 71 + pass * 101 + 13) & 255);
        done_ie_i = m[0];
        bnd_ie_i  = m[1] ^ pass[0];
        run_scan(4'(m), (m % 3) == 2);
        clear_flags();
      end
    end

    // R7 window edges, single channel scans
    lo_lim_i = 4'd4;
    hi_lim_i = 4'd11;
    bnd_ie_i = 1'b1;
    data_tab[2] = 8'h40; run_scan(4'b0100, 1'b0); clear_flags();
    data_tab[2] = 8'hBF; run_scan(4'b0100, 1'b0); clear_flags();
    data_tab[2] = 8'h3F; run_scan(4'b0100, 1'b0); clear_flags();
    data_tab[2] = 8'hC0; run_scan(4'b0100, 1'b0); clear_flags();
    // only one channel outside among several: every result is checked
    data_tab[0] = 8'h55; data_tab[1] = 8'h66; data_tab[3] = 8'hF1;
    run_scan(4'b1011, 1'b0);
    clear_flags();

    // R10 stray done while idle changes nothing
    @(negedge clk);
    stray_data = 8'hEE;
    stray_done = 1'b1;
    @(negedge clk);
    stray_done = 1'b0;
    @(negedge clk);
    check_results("R10 stray done ignored");
    check(busy_o == 1'b0 && bnd_flag_o == 1'b0 && done_flag_o == 1'b0,
          "R10 stray done no side effect", {busy_o, bnd_flag_o, done_flag_o}, 0);

    // R8 clear collides with final store of an out-of-window code
    collide_mode = 1'b1;
    data_tab[1] = 8'hF7;
    run_scan(4'b0010, 1'b0);
    collide_mode = 1'b0;
    check(done_flag_o == 1'b1, "R8 set wins over clear (done)", done_flag_o, 1);
    check(bnd_flag_o == 1'b1, "R8 set wins over clear (bnd)", bnd_flag_o, 1);
    clear_flags();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule